// File: doc/BRIEF.md
# Double-Banked IN Endpoint Transmit Buffer

This block holds outgoing packets for one USB IN endpoint in two alternating banks. A local microcontroller writes bytes into whichever bank is the current fill bank, then pulses a packet-ready command. That command marks the bank as transmittable and moves filling to the other bank. While one bank is filled, the other one can be streamed out to a device-side serial engine.

The engine presents strobes for an IN token, for each byte taken, for a host ACK and for a response timeout. On an IN token the block begins streaming the current send bank, or pulses a NAK indication when no bank is ready. A bank is freed only by ACK. A timeout leaves the bank queued and rewinds it, so the next IN token sends the same packet again from the first byte.

Software sees two outputs. The packet-ready status reads 1 only when no bank is free to write. The level interrupt, gated by an enable input, stays high whenever a bank can accept data. Each bank keeps its own byte count, so short and zero-length packets are sent as written.

Top module: `pp_tx_buffer`

## Requirements
- R1: After reset no bank is ready, filling and sending both start at bank A (bank select value 0), eng_tx_busy, eng_tx_valid, eng_nak, stat_pkt_rdy and overrun are 0, and irq equals irq_en.
- R2: A write accepted into the fill bank is stored at the next byte position of that bank. A bank holds at most DEPTH bytes (64 by default), and a further write to a full bank is dropped and sets overrun.
- R3: A packet-ready pulse while the fill bank is free marks that bank ready and moves filling to the other bank, so banks are filled strictly as A, B, A, B.
- R4: An IN token while idle with the send bank ready starts sending that bank from byte 0. eng_tx_valid is high while bytes remain, eng_rd_byte advances one byte per cycle, and eng_tx_last is high on the final byte only.
- R5: An IN token while idle with the send bank not ready produces a one-cycle eng_nak in the following cycle and does not start a transfer.
- R6: stat_pkt_rdy is 1 exactly when both banks are ready and unacknowledged. irq equals irq_en AND (a bank is free to write), so it stays high after the first packet-ready pulse.
- R7: eng_ack during a transfer clears that bank's ready flag and byte count, ends the transfer and moves sending to the other bank, so the next IN token sends the other bank.
- R8: eng_tmo during a transfer ends it but leaves the bank ready, and the next IN token resends it from byte 0.
- R9: While no bank is free, writes are dropped and set the sticky overrun flag, and packet-ready pulses have no effect. overrun clears only on reset.
- R10: Bytes written into the fill bank during a transfer do not disturb the data being sent from the other bank.
- R11: A bank marked ready with no bytes written is a zero-length packet: the IN token sets eng_tx_busy while eng_tx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Byte write strobe from the microcontroller |
| cpu_wdata | input | DATA_W | Byte to write |
| cpu_pkt_rdy | input | 1 | Packet-ready command pulse |
| irq_en | input | 1 | Interrupt enable |
| eng_in_tok | input | 1 | IN token received strobe |
| eng_rd_byte | input | 1 | Engine takes the current byte |
| eng_ack | input | 1 | Host ACK handshake strobe |
| eng_tmo | input | 1 | No-handshake timeout strobe |
| eng_tx_data | output | DATA_W | Byte at the read position of the send bank |
| eng_tx_valid | output | 1 | Transfer active and bytes remain |
| eng_tx_last | output | 1 | Current byte is the last of the packet |
| eng_tx_busy | output | 1 | Transfer in progress |
| eng_nak | output | 1 | One-cycle NAK indication |
| stat_pkt_rdy | output | 1 | No bank free to write |
| irq | output | 1 | Level interrupt: a bank is free to write |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
A wrong bank pointer shows up at the first byte of the next transfer, because eng_tx_data carries the other bank's data. A wrong ready flag shows up at once in stat_pkt_rdy and irq, or on the next IN token as a NAK where data was expected, or as data where a NAK was expected. A count or read pointer that is out of step shows up within one packet: eng_tx_last arrives on the wrong byte, or eng_tx_valid drops early or late. The bench keeps a model of both banks and compares data, framing and flags after every operation, so a fault appears within a few cycles of the operation that caused it.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;

   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_e;

   function automatic bank_e other_bank(bank_e b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction

endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem
   import pp_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  bank_e             wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  bank_e             rd_bank,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] bank_q [2];

   for (genvar gb = 0; gb < 2; gb++) begin : g_bank
      localparam bank_e ME = (gb == 0) ? BANK_A : BANK_B;
      logic [DATA_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == ME)) begin
            store[wr_addr] <= wr_data;
         end
      end

      assign bank_q[gb] = store[rd_addr];
   end

   assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl
   import pp_tx_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          mark_req,
   input  logic          release_req,
   output bank_e         fill_bank,
   output bank_e         send_bank,
   output logic          fill_free,
   output logic          wr_accept,
   output logic [AW-1:0] wr_addr,
   output logic          send_ready,
   output logic [CW-1:0] send_cnt,
   output logic          overrun
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [CW-1:0] cnt_q [2];
   logic          rdy_q [2];
   bank_e         fill_q;
   bank_e         send_q;
   logic          ovr_q;
   logic          mark_ok;

   assign fill_free  = !rdy_q[fill_q];
   assign wr_accept  = wr_req && fill_free && (cnt_q[fill_q] < DEPTH_C);
   assign mark_ok    = mark_req && fill_free;
   assign wr_addr    = cnt_q[fill_q][AW-1:0];
   assign send_ready = rdy_q[send_q];
   assign send_cnt   = cnt_q[send_q];
   assign fill_bank  = fill_q;
   assign send_bank  = send_q;
   assign overrun    = ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            cnt_q[b] <= '0;
            rdy_q[b] <= 1'b0;
         end
      end else begin
         for (int b = 0; b < 2; b++) begin
            if (release_req && (send_q == bank_e'(b[0]))) begin
               cnt_q[b] <= '0;
               rdy_q[b] <= 1'b0;
            end else if (fill_q == bank_e'(b[0])) begin
               if (wr_accept) cnt_q[b] <= cnt_q[b] + CW'(1);
               if (mark_ok)   rdy_q[b] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= BANK_A;
         send_q <= BANK_A;
         ovr_q  <= 1'b0;
      end else begin
         if (mark_ok)             fill_q <= other_bank(fill_q);
         if (release_req)         send_q <= other_bank(send_q);
         if (wr_req && !wr_accept) ovr_q <= 1'b1;
      end
   end

   a_r2_count_bound_a: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[0] <= DEPTH_C);
   a_r2_count_bound_b: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[1] <= DEPTH_C);
   a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      release_req |=> !rdy_q[$past(send_q)]);
   a_r3_fill_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_req && fill_free) |=> (rdy_q[$past(fill_q)] && fill_q != $past(fill_q)));

endmodule

// File: rtl/pp_send_seq.sv
module pp_send_seq #(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_tok,
   input  logic          rd_byte,
   input  logic          ack,
   input  logic          tmo,
   input  logic          bank_ready,
   input  logic [CW-1:0] bank_cnt,
   output logic          busy,
   output logic [CW-1:0] rd_ptr,
   output logic          release_req,
   output logic          nak,
   output logic          tx_valid,
   output logic          tx_last
);

   logic          busy_q;
   logic [CW-1:0] ptr_q;
   logic          nak_q;

   assign busy        = busy_q;
   assign rd_ptr      = ptr_q;
   assign nak         = nak_q;
   assign release_req = busy_q && ack;
   assign tx_valid    = busy_q && (ptr_q < bank_cnt);
   assign tx_last     = tx_valid && ((ptr_q + CW'(1)) == bank_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
         nak_q  <= 1'b0;
      end else begin
         nak_q <= in_tok && !busy_q && !bank_ready;
         if (!busy_q) begin
            if (in_tok && bank_ready) begin
               busy_q <= 1'b1;
               ptr_q  <= '0;
            end
         end else if (ack || tmo) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
         end else if (rd_byte && tx_valid) begin
            ptr_q <= ptr_q + CW'(1);
         end
      end
   end

   a_r4_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> busy_q);
   a_r5_nak_no_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      nak_q |-> !busy_q);
   a_r8_timeout_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && tmo && !ack) |=> (!busy_q && ptr_q == '0));
   a_r4_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && in_tok && bank_ready) |=> (busy_q && ptr_q == '0));

endmodule

// File: rtl/pp_tx_buffer.sv
module pp_tx_buffer
   import pp_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 64,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_pkt_rdy,
   input  logic              irq_en,
   input  logic              eng_in_tok,
   input  logic              eng_rd_byte,
   input  logic              eng_ack,
   input  logic              eng_tmo,
   output logic [DATA_W-1:0] eng_tx_data,
   output logic              eng_tx_valid,
   output logic              eng_tx_last,
   output logic              eng_tx_busy,
   output logic              eng_nak,
   output logic              stat_pkt_rdy,
   output logic              irq,
   output logic              overrun
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pp_tx_buffer: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pp_tx_buffer: DATA_W must be at least 1");
   end

   bank_e         fill_bank;
   bank_e         send_bank;
   logic          fill_free;
   logic          wr_accept;
   logic [AW-1:0] wr_addr;
   logic          send_ready;
   logic [CW-1:0] send_cnt;
   logic [CW-1:0] rd_ptr;
   logic          release_req;

   pp_bank_ctrl #(.DEPTH(DEPTH)) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_req      (cpu_wr),
      .mark_req    (cpu_pkt_rdy),
      .release_req (release_req),
      .fill_bank   (fill_bank),
      .send_bank   (send_bank),
      .fill_free   (fill_free),
      .wr_accept   (wr_accept),
      .wr_addr     (wr_addr),
      .send_ready  (send_ready),
      .send_cnt    (send_cnt),
      .overrun     (overrun)
   );

   pp_send_seq #(.DEPTH(DEPTH)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_tok      (eng_in_tok),
      .rd_byte     (eng_rd_byte),
      .ack         (eng_ack),
      .tmo         (eng_tmo),
      .bank_ready  (send_ready),
      .bank_cnt    (send_cnt),
      .busy        (eng_tx_busy),
      .rd_ptr      (rd_ptr),
      .release_req (release_req),
      .nak         (eng_nak),
      .tx_valid    (eng_tx_valid),
      .tx_last     (eng_tx_last)
   );

   pp_bank_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_mem (
      .clk     (clk),
      .wr_en   (wr_accept),
      .wr_bank (fill_bank),
      .wr_addr (wr_addr),
      .wr_data (cpu_wdata),
      .rd_bank (send_bank),
      .rd_addr (rd_ptr[AW-1:0]),
      .rd_data (eng_tx_data)
   );

   assign stat_pkt_rdy = !fill_free;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_en && fill_free;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_en && fill_free;
   end

   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   a_r9_full_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pkt_rdy && cpu_wr) |=> overrun);
   a_r6_status_holds_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pkt_rdy && !eng_ack) |=> stat_pkt_rdy);

endmodule

// File: tb/test_pp_tx_buffer.sv
module test_pp_tx_buffer;

   localparam int DW = 8;
   localparam int DP = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_pkt_rdy = 1'b0;
   logic          irq_en = 1'b1;
   logic          eng_in_tok = 1'b0;
   logic          eng_rd_byte = 1'b0;
   logic          eng_ack = 1'b0;
   logic          eng_tmo = 1'b0;
   logic [DW-1:0] eng_tx_data;
   logic          eng_tx_valid, eng_tx_last, eng_tx_busy, eng_nak;
   logic          stat_pkt_rdy, irq, overrun;

   always #10 clk = ~clk;

   pp_tx_buffer #(.DATA_W(DW), .DEPTH(DP)) i_pp_tx_buffer (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_pkt_rdy(cpu_pkt_rdy), .irq_en(irq_en), .eng_in_tok(eng_in_tok),
      .eng_rd_byte(eng_rd_byte), .eng_ack(eng_ack), .eng_tmo(eng_tmo),
      .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
      .eng_tx_last(eng_tx_last), .eng_tx_busy(eng_tx_busy), .eng_nak(eng_nak),
      .stat_pkt_rdy(stat_pkt_rdy), .irq(irq), .overrun(overrun)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_mem [2][DP];
   int  m_cnt [2];
   bit  m_rdy [2];
   int  m_fill, m_send, m_ptr;
   bit  m_busy, m_ovr;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_status();
      return m_rdy[m_fill];
   endfunction

   function automatic bit exp_irq();
      return irq_en && !m_rdy[m_fill];
   endfunction

   task automatic check_flags(string req);
      chk(stat_pkt_rdy == exp_status(), {req, " status"}, int'(stat_pkt_rdy), int'(exp_status()));
      chk(irq == exp_irq(), {req, " irq"}, int'(irq), int'(exp_irq()));
      chk(overrun == m_ovr, {req, " overrun"}, int'(overrun), int'(m_ovr));
      chk(eng_tx_busy == m_busy, {req, " busy"}, int'(eng_tx_busy), int'(m_busy));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
         m_cnt[b] = 0;
         m_rdy[b] = 1'b0;
      end
      m_fill = 0; m_send = 0; m_ptr = 0; m_busy = 1'b0; m_ovr = 1'b0;
   endtask

   task automatic do_write(logic [DW-1:0] d, string req);
      cpu_wr = 1'b1; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
      if (!m_rdy[m_fill] && m_cnt[m_fill] < DP) begin
         m_mem[m_fill][m_cnt[m_fill]] = d;
         m_cnt[m_fill]++;
      end else begin
         m_ovr = 1'b1;
      end
      check_flags(req);
   endtask

   task automatic do_mark(string req);
      cpu_pkt_rdy = 1'b1;
      @(negedge clk);
      cpu_pkt_rdy = 1'b0;
      if (!m_rdy[m_fill]) begin
         m_rdy[m_fill] = 1'b1;
         m_fill ^= 1;
      end
      check_flags(req);
   endtask

   task automatic do_in(string req);
      bit exp_nak;
      exp_nak = 1'b0;
      eng_in_tok = 1'b1;
      @(negedge clk);
      eng_in_tok = 1'b0;
      if (!m_busy) begin
         if (m_rdy[m_send]) begin
            m_busy = 1'b1; m_ptr = 0;
         end else begin
            exp_nak = 1'b1;
         end
      end
      chk(eng_nak == exp_nak, {req, " nak"}, int'(eng_nak), int'(exp_nak));
      check_flags(req);
      if (exp_nak) begin
         @(negedge clk);
         chk(eng_nak == 1'b0, {req, " nak width"}, int'(eng_nak), 0);
      end
   endtask

   task automatic do_read(string req);
      bit ev, el;
      ev = m_busy && (m_ptr < m_cnt[m_send]);
      el = ev && (m_ptr == m_cnt[m_send] - 1);
      chk(eng_tx_valid == ev, {req, " valid"}, int'(eng_tx_valid), int'(ev));
      chk(eng_tx_last == el, {req, " last"}, int'(eng_tx_last), int'(el));
      if (ev) chk(eng_tx_data == m_mem[m_send][m_ptr], {req, " data"},
                  int'(eng_tx_data), int'(m_mem[m_send][m_ptr]));
      eng_rd_byte = 1'b1;
      @(negedge clk);
      eng_rd_byte = 1'b0;
      if (ev) m_ptr++;
   endtask

   task automatic do_ack(string req);
      eng_ack = 1'b1;
      @(negedge clk);
      eng_ack = 1'b0;
      if (m_busy) begin
         m_rdy[m_send] = 1'b0; m_cnt[m_send] = 0;
         m_send ^= 1; m_busy = 1'b0; m_ptr = 0;
      end
      check_flags(req);
   endtask

   task automatic do_tmo(string req);
      eng_tmo = 1'b1;
      @(negedge clk);
      eng_tmo = 1'b0;
      if (m_busy) begin
         m_busy = 1'b0; m_ptr = 0;
      end
      check_flags(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1: reset state
      check_flags("R1");
      chk(eng_tx_valid == 1'b0, "R1 valid", int'(eng_tx_valid), 0);
      chk(eng_nak == 1'b0, "R1 nak", int'(eng_nak), 0);
      // R5: token with nothing queued
      do_in("R5");
      // R3 / R6: first bank queued, interrupt stays high
      do_write(8'h11, "R2"); do_write(8'h22, "R2"); do_write(8'h33, "R2");
      do_mark("R3 first mark");
      chk(irq == 1'b1, "R6 irq after first mark", int'(irq), 1);
      for (int i = 0; i < 5; i++) do_write(8'(8'h40 + i), "R2");
      do_mark("R3 second mark");
      chk(stat_pkt_rdy == 1'b1, "R6 both ready", int'(stat_pkt_rdy), 1);
      // R9: no bank free
      do_write(8'hEE, "R9 write dropped");
      do_mark("R9 mark ignored");
      // R4 then R8
      do_in("R4");
      for (int i = 0; i < 4; i++) do_read("R4");
      do_tmo("R8");
      do_in("R8 resend");
      chk(eng_tx_data == 8'h11, "R8 first byte", int'(eng_tx_data), 8'h11);
      for (int i = 0; i < 3; i++) do_read("R8");
      do_ack("R7");
      // R7 / R10: send bank B while refilling bank A
      do_in("R7 other bank");
      chk(eng_tx_data == 8'h40, "R7 bank B byte", int'(eng_tx_data), 8'h40);
      do_read("R10");
      do_write(8'h99, "R10"); do_write(8'h98, "R10");
      do_mark("R10");
      for (int i = 0; i < 5; i++) do_read("R10");
      do_ack("R7");
      do_in("R10 refilled");
      for (int i = 0; i < 2; i++) do_read("R10");
      do_ack("R7");
      // R11: zero-length packet
      do_mark("R11");
      do_in("R11");
      chk(eng_tx_busy == 1'b1, "R11 busy", int'(eng_tx_busy), 1);
      do_read("R11");
      do_ack("R11");
      irq_en = 1'b0;
      @(negedge clk);
      check_flags("R6 irq disabled");
      irq_en = 1'b1;
      // R2: full bank boundary
      do_reset();
      for (int i = 0; i < DP; i++) do_write(8'($urandom), "R2 fill");
      chk(overrun == 1'b0, "R2 no overrun at depth", int'(overrun), 0);
      do_write(8'h5A, "R2 beyond depth");
      do_mark("R3");
      do_in("R4 full");
      for (int i = 0; i < DP + 1; i++) do_read("R4 full");
      do_ack("R7");
      // random phase
      do_reset();
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom % 10);
         if (op < 5) begin
            do_write(8'($urandom), "R2 rnd");
         end else if (op < 7) begin
            do_mark("R3 rnd");
         end else begin
            do_in("R4 rnd");
            if (m_busy) begin
               int n;
               n = (($urandom % 4) == 0) ? int'($urandom % (m_cnt[m_send] + 1)) : m_cnt[m_send];
               for (int k = 0; k < n; k++) do_read("R4 rnd");
               if (n == m_cnt[m_send] && ($urandom % 4) != 0) do_ack("R7 rnd");
               else do_tmo("R8 rnd");
            end
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule